// File: doc/BRIEF.md
# Programmable Interrupt Aggregator

The block gathers thirty-two interrupt request lines into one processor interrupt. Twenty of the lines come from expansion slots, four per slot, in pin order A, B, C, D. Line 31 is the cascade output of a legacy-bus interrupt controller. Lines 20 to 30 are not connected. Each raw line first passes through a two-flop synchroniser. Its polarity bit then turns it into an active-high signal. Its trigger bit then chooses between live level sensing and a sticky edge latch.

Software works through a small register port. The ports are write-enable, address, write data and combinational read data. Pending status ANDed with the enable mask drives `cpu_irq`. The same masked vector also drives a lowest-numbered-line encoder, `irq_id` with `irq_id_valid`, so a dispatcher can find the first line to serve without scanning.

Edge events are dismissed in two steps. Software writes a 1 to the line's clear bit, then writes 0. A reset register accepts one magic word, and that word makes a single-cycle system reset request. The request comes from a two-state machine. State KICK_IDLE moves to KICK_FIRE on a write of the magic word. State KICK_FIRE always returns to KICK_IDLE on the next clock.

Top module: `irq_funnel`

## Requirements
- R1: After reset, the enable mask, trigger and clear registers read zero, and the polarity register reads 0x80000000. `cpu_irq`, `irq_id_valid` and `sys_reset_req` are low.
- R2: A line whose trigger bit is 0 is level-sensitive, and its summary bit shows the live synchronised input. A polarity bit of 1 means active-high, and 0 means active-low. The bit shows a change within four clocks.
- R3: A line whose trigger bit is 1 sets its summary bit on an inactive-to-active transition. The bit stays set after the input returns to inactive.
- R4: While a line's clear bit is 1, its edge bit reads 0 and new edges on that line are ignored. Once 0 is written back, new edges latch again. Clear bits have no effect on level-sensitive lines.
- R5: The cascade line (bit 31) follows R2 to R4 in the same way. Its edge latch is dismissed by writing 0x80000000 and then 0 to the clear register.
- R6: Summary bits 20 to 30 always read 0. They never raise `cpu_irq` or `irq_id_valid`, whatever the inputs, polarity or mask.
- R7: `cpu_irq` is 1 exactly when some summary bit has its enable bit at 1.
- R8: `irq_id_valid` equals `cpu_irq`. While it is 1, `irq_id` is the lowest-numbered line that is both pending and enabled.
- R9: A write of 0x0000DEAD to address 5 raises `sys_reset_req` for exactly one clock, in the cycle after the write. Address 5 reads 0.
- R10: A write of any other value to address 5 leaves `sys_reset_req` low and changes no other register.
- R11: The register map is as follows. Address 0 is the request summary and is read-only. Address 1 is the enable mask. Address 2 is the trigger select, where 1 means edge. Address 3 is polarity. Address 4 is clear. Registers 1 to 4 read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 32 | Raw, asynchronous interrupt request lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cpu_irq | output | 1 | Aggregated processor interrupt |
| irq_id | output | 5 | Lowest pending enabled line |
| irq_id_valid | output | 1 | `irq_id` is meaningful |
| sys_reset_req | output | 1 | One-clock system reset request |

## Verification
Random level-mode rounds draw the mask, polarity and inputs independently. They separate a polarity inversion error from a masking error, and they exercise the lowest-line encoder across many multi-bit vectors. Directed patterns drive only the reserved lines to their active level, which tells true suppression of those lines apart from simple masking. Edge sequences pulse one line before, during and after a clear hold. This tells a sticky latch apart from live sensing, and a held clear apart from a one-shot clear. Writes to the reset register with a near-miss word and with the magic word test the pulse's width and what triggers it.

// File: rtl/irq_funnel_pkg.sv
package irq_funnel_pkg;
    localparam int LINES       = 32;
    localparam int IDW         = $clog2(LINES);
    localparam int SLOT_LINES  = 20;
    localparam int CASCADE_BIT = 31;
    localparam int ADDR_W      = 3;

    localparam logic [LINES-1:0] ONE_HOT0  = {{(LINES-1){1'b0}}, 1'b1};
    localparam logic [LINES-1:0] LIVE_BITS =
        {{(LINES-SLOT_LINES){1'b0}}, {SLOT_LINES{1'b1}}} | (ONE_HOT0 << CASCADE_BIT);
    localparam logic [LINES-1:0] POL_RESET = ONE_HOT0 << CASCADE_BIT;
    localparam logic [LINES-1:0] KICK_WORD = 32'h0000_DEAD;

    localparam logic [ADDR_W-1:0] ADR_SUMMARY = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_ENABLE  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_TRIGGER = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_POLAR   = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_CLEAR   = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_KICK    = 3'd5;

    typedef enum logic [0:0] {
        KICK_IDLE = 1'b0,
        KICK_FIRE = 1'b1
    } kick_state_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = irq_funnel_pkg::LINES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            synced <= '0;
        end else begin
            meta_q <= raw;
            synced <= meta_q;
        end
    end
endmodule

// File: rtl/irq_detect.sv
module irq_detect #(
    parameter int W = irq_funnel_pkg::LINES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] synced,
    input  logic [W-1:0] polarity,
    input  logic [W-1:0] edge_sel,
    input  logic [W-1:0] clr_hold,
    input  logic [W-1:0] live,
    output logic [W-1:0] status
);
    for (genvar i = 0; i < W; i++) begin : g_line
        logic act;
        logic prev_q;
        logic sticky_q;

        assign act = polarity[i] ? synced[i] : ~synced[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q   <= 1'b0;
                sticky_q <= 1'b0;
            end else begin
                prev_q <= act;
                if (!edge_sel[i] || clr_hold[i]) begin
                    sticky_q <= 1'b0;
                end else if (act && !prev_q) begin
                    sticky_q <= 1'b1;
                end
            end
        end

        assign status[i] = live[i] & (edge_sel[i] ? sticky_q : act);
    end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int W   = irq_funnel_pkg::LINES,
    parameter int IDW = $clog2(W)
) (
    input  logic [W-1:0]   req,
    output logic [IDW-1:0] id,
    output logic           valid
);
    always_comb begin
        id    = '0;
        valid = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                id    = i[IDW-1:0];
                valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_funnel_pkg::*;
#(
    parameter int W = LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    input  logic [W-1:0]      summary,
    output logic [W-1:0]      reg_rdata,
    output logic [W-1:0]      enable_q,
    output logic [W-1:0]      trigger_q,
    output logic [W-1:0]      polar_q,
    output logic [W-1:0]      clear_q,
    output logic              kick_pulse
);
    kick_state_t kick_q, kick_d;
    logic        kick_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q  <= '0;
            trigger_q <= '0;
            polar_q   <= POL_RESET;
            clear_q   <= '0;
        end else if (reg_we) begin
            unique case (reg_addr)
                ADR_ENABLE:  enable_q  <= reg_wdata;
                ADR_TRIGGER: trigger_q <= reg_wdata;
                ADR_POLAR:   polar_q   <= reg_wdata;
                ADR_CLEAR:   clear_q   <= reg_wdata;
                default:     ;
            endcase
        end
    end

    assign kick_hit = reg_we && (reg_addr == ADR_KICK) && (reg_wdata == KICK_WORD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kick_q <= KICK_IDLE;
        end else begin
            kick_q <= kick_d;
        end
    end

    always_comb begin
        kick_d = kick_q;
        unique case (kick_q)
            KICK_IDLE: if (kick_hit) kick_d = KICK_FIRE;
            KICK_FIRE: kick_d = KICK_IDLE;
            default:   kick_d = KICK_IDLE;
        endcase
    end

    always_comb begin
        kick_pulse = 1'b0;
        unique case (kick_q)
            KICK_IDLE: kick_pulse = 1'b0;
            KICK_FIRE: kick_pulse = 1'b1;
            default:   kick_pulse = 1'b0;
        endcase
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADR_SUMMARY: reg_rdata = summary;
            ADR_ENABLE:  reg_rdata = enable_q;
            ADR_TRIGGER: reg_rdata = trigger_q;
            ADR_POLAR:   reg_rdata = polar_q;
            ADR_CLEAR:   reg_rdata = clear_q;
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_funnel.sv
module irq_funnel
    import irq_funnel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  irq_lines,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [LINES-1:0]  reg_wdata,
    output logic [LINES-1:0]  reg_rdata,
    output logic              cpu_irq,
    output logic [IDW-1:0]    irq_id,
    output logic              irq_id_valid,
    output logic              sys_reset_req
);
    logic [LINES-1:0] synced;
    logic [LINES-1:0] status;
    logic [LINES-1:0] enable_q;
    logic [LINES-1:0] trigger_q;
    logic [LINES-1:0] polar_q;
    logic [LINES-1:0] clear_q;
    logic [LINES-1:0] armed;

    irq_sync #(.W(LINES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (irq_lines),
        .synced (synced)
    );

    irq_detect #(.W(LINES)) detect_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .synced   (synced),
        .polarity (polar_q),
        .edge_sel (trigger_q),
        .clr_hold (clear_q),
        .live     (LIVE_BITS),
        .status   (status)
    );

    irq_regs #(.W(LINES)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .summary    (status),
        .reg_rdata  (reg_rdata),
        .enable_q   (enable_q),
        .trigger_q  (trigger_q),
        .polar_q    (polar_q),
        .clear_q    (clear_q),
        .kick_pulse (sys_reset_req)
    );

    assign armed   = status & enable_q;
    assign cpu_irq = |armed;

    irq_prio #(.W(LINES), .IDW(IDW)) prio_i (
        .req   (armed),
        .id    (irq_id),
        .valid (irq_id_valid)
    );
endmodule

// File: rtl/irq_funnel_chk.sv
module irq_funnel_chk
    import irq_funnel_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [LINES-1:0]  reg_wdata,
    input logic [LINES-1:0]  reg_rdata,
    input logic              cpu_irq,
    input logic [IDW-1:0]    irq_id,
    input logic              irq_id_valid,
    input logic              sys_reset_req
);
    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADR_SUMMARY) |-> ((reg_rdata & ~LIVE_BITS) == '0)); // R6

    AST_ID_NOT_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_id_valid |-> ((int'(irq_id) < SLOT_LINES) || (int'(irq_id) == CASCADE_BIT))); // R6

    AST_ID_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_id_valid && reg_addr == ADR_SUMMARY) |-> reg_rdata[irq_id]); // R8

    AST_IRQ_HAS_ID: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> irq_id_valid); // R8

    AST_KICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |=> !sys_reset_req); // R9

    AST_KICK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_reset_req) |-> $past(reg_we && reg_addr == ADR_KICK && reg_wdata == KICK_WORD)); // R10
endmodule

bind irq_funnel irq_funnel_chk chk_i (.*);

// File: tb/irq_funnel_tb_top.sv
`timescale 1ns/1ps
module irq_funnel_tb_top;
    import irq_funnel_pkg::*;

    localparam logic [31:0] IDLE_LINES = 32'h7FFF_FFFF;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [LINES-1:0]  irq_lines;
    logic              reg_we;
    logic [ADDR_W-1:0] reg_addr;
    logic [LINES-1:0]  reg_wdata;
    logic [LINES-1:0]  reg_rdata;
    logic              cpu_irq;
    logic [IDW-1:0]    irq_id;
    logic              irq_id_valid;
    logic              sys_reset_req;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    irq_funnel dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_lines     (irq_lines),
        .reg_we        (reg_we),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .cpu_irq       (cpu_irq),
        .irq_id        (irq_id),
        .irq_id_valid  (irq_id_valid),
        .sys_reset_req (sys_reset_req)
    );

    function automatic logic [31:0] level_view(input logic [31:0] lines, input logic [31:0] pol);
        return ((lines & pol) | (~lines & ~pol)) & LIVE_BITS;
    endfunction

    function automatic logic [5:0] lowest(input logic [31:0] v);
        for (int i = 0; i < 32; i++) begin
            if (v[i]) return {1'b1, i[4:0]};
        end
        return 6'd0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic summary_line();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic check_outputs(input string tag, input logic [31:0] exp_sum, input logic [31:0] mask);
        logic [31:0] v;
        logic [5:0]  lo;
        rd(ADR_SUMMARY, v);
        chk({tag, " summary"}, v, exp_sum);
        chk({tag, " R7 cpu_irq"}, {31'd0, cpu_irq}, {31'd0, (exp_sum & mask) != 0});
        lo = lowest(exp_sum & mask);
        chk({tag, " R8 id_valid"}, {31'd0, irq_id_valid}, {31'd0, lo[5]});
        if (lo[5]) chk({tag, " R8 id"}, {27'd0, irq_id}, {27'd0, lo[4:0]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary_line();
    end

    initial begin
        logic [31:0] v, m, p, l, mask_keep;
        rst_n     = 1'b0;
        irq_lines = IDLE_LINES;
        reg_we    = 1'b0;
        reg_addr  = '0;
        reg_wdata = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R1 reset state
        rd(ADR_SUMMARY, v); chk("R1 summary", v, 32'h0);
        rd(ADR_ENABLE, v);  chk("R1 enable", v, 32'h0);
        rd(ADR_TRIGGER, v); chk("R1 trigger", v, 32'h0);
        rd(ADR_POLAR, v);   chk("R1 polarity", v, 32'h8000_0000);
        rd(ADR_CLEAR, v);   chk("R1 clear", v, 32'h0);
        chk("R1 outputs", {29'd0, cpu_irq, irq_id_valid, sys_reset_req}, 32'h0);

        // R11 readback
        wr(ADR_ENABLE, 32'h1234_5678); rd(ADR_ENABLE, v); chk("R11 enable rb", v, 32'h1234_5678);
        wr(ADR_CLEAR, 32'hA5A5_0F0F);  rd(ADR_CLEAR, v);  chk("R11 clear rb", v, 32'hA5A5_0F0F);
        wr(ADR_CLEAR, 32'h0);
        wr(ADR_ENABLE, 32'h0);

        // R2 R6 R7 R8 random level rounds
        for (int k = 0; k < 40; k++) begin
            m = $urandom(); p = $urandom(); l = $urandom();
            if (k % 5 == 0) m = 32'hFFFF_FFFF;
            wr(ADR_ENABLE, m);
            wr(ADR_POLAR, p);
            irq_lines = l;
            settle();
            check_outputs("R2 R6 level", level_view(l, p), m);
            if (k % 4 == 0) begin
                wr(ADR_CLEAR, $urandom() | 32'h1);
                settle();
                rd(ADR_SUMMARY, v);
                chk("R4 clear ignored on level", v, level_view(l, p));
                wr(ADR_CLEAR, 32'h0);
            end
        end

        // R6 only reserved lines active, full mask
        wr(ADR_ENABLE, 32'hFFFF_FFFF);
        wr(ADR_POLAR, 32'hFFF0_0000);
        irq_lines = 32'h7FFF_FFFF;
        settle();
        check_outputs("R6 reserved active", 32'h0, 32'hFFFF_FFFF);

        // R8 priority directed
        wr(ADR_POLAR, 32'hFFFF_FFFF);
        irq_lines = 32'h8008_0000;
        settle();
        check_outputs("R8 lowest 19", 32'h8008_0000, 32'hFFFF_FFFF);
        wr(ADR_ENABLE, 32'hFFF7_FFFF);
        check_outputs("R8 masked to 31", 32'h8008_0000, 32'hFFF7_FFFF);
        wr(ADR_ENABLE, 32'h0);
        check_outputs("R7 mask zero", 32'h8008_0000, 32'h0);

        // R3 edge latch on line 5 (active-low)
        wr(ADR_POLAR, 32'h8000_0000);
        irq_lines = IDLE_LINES;
        settle();
        wr(ADR_TRIGGER, 32'h0000_0020);
        settle();
        rd(ADR_SUMMARY, v); chk("R3 no edge yet", v, 32'h0);
        irq_lines[5] = 1'b0; settle();
        rd(ADR_SUMMARY, v); chk("R3 edge latched", v, 32'h20);
        irq_lines[5] = 1'b1; settle();
        rd(ADR_SUMMARY, v); chk("R3 sticky", v, 32'h20);
        wr(ADR_ENABLE, 32'h20);
        check_outputs("R3 R7 edge irq", 32'h20, 32'h20);

        // R4 clear hold then release
        wr(ADR_CLEAR, 32'h20); settle();
        rd(ADR_SUMMARY, v); chk("R4 cleared", v, 32'h0);
        irq_lines[5] = 1'b0; settle(); irq_lines[5] = 1'b1; settle();
        rd(ADR_SUMMARY, v); chk("R4 edge ignored in hold", v, 32'h0);
        chk("R4 no irq in hold", {31'd0, cpu_irq}, 32'h0);
        wr(ADR_CLEAR, 32'h0); settle();
        rd(ADR_SUMMARY, v); chk("R4 released quiet", v, 32'h0);
        irq_lines[5] = 1'b0; settle(); irq_lines[5] = 1'b1; settle();
        rd(ADR_SUMMARY, v); chk("R4 edge relatches", v, 32'h20);
        wr(ADR_CLEAR, 32'h20); wr(ADR_CLEAR, 32'h0);

        // R5 cascade edge
        wr(ADR_TRIGGER, 32'h8000_0020);
        settle();
        irq_lines[31] = 1'b1; settle();
        rd(ADR_SUMMARY, v); chk("R5 cascade latched", v, 32'h8000_0000);
        irq_lines[31] = 1'b0; settle();
        rd(ADR_SUMMARY, v); chk("R5 cascade sticky", v, 32'h8000_0000);
        wr(ADR_CLEAR, 32'h8000_0000); settle();
        rd(ADR_SUMMARY, v); chk("R5 cascade cleared", v, 32'h0);
        wr(ADR_CLEAR, 32'h0); settle();
        rd(ADR_SUMMARY, v); chk("R5 cascade stays clear", v, 32'h0);

        // R10 near-miss word
        rd(ADR_ENABLE, mask_keep);
        wr(ADR_KICK, 32'h0000_DEAC);
        chk("R10 no pulse", {31'd0, sys_reset_req}, 32'h0);
        @(negedge clk);
        chk("R10 no pulse later", {31'd0, sys_reset_req}, 32'h0);
        rd(ADR_ENABLE, v); chk("R10 enable untouched", v, mask_keep);
        rd(ADR_TRIGGER, v); chk("R10 trigger untouched", v, 32'h8000_0020);

        // R9 magic word
        wr(ADR_KICK, 32'h0000_DEAD);
        chk("R9 pulse high", {31'd0, sys_reset_req}, 32'h1);
        @(negedge clk);
        chk("R9 pulse one cycle", {31'd0, sys_reset_req}, 32'h0);
        rd(ADR_KICK, v); chk("R9 kick reads zero", v, 32'h0);

        summary_line();
    end
endmodule